// File: doc/BRIEF.md
# Shift-Flag, Scan and Cut Unit

This unit performs four bit-manipulation operations for a 32-bit integer datapath. Two are shifts that record the bits pushed off the edge of the word in a condition-code flag. The third is a scan that counts leading zeros. The fourth is a cut that takes a 32-bit window out of a 64-bit pair of operands. Each accepted request carries an opcode, two operands, an amount field and the incoming 4-bit condition code. The unit returns a result word and the condition code after the update.

Everything is computed combinationally from the request. The result and condition code are then captured in one register stage, so an answer appears one cycle after its request. Zero and negative flags are not produced here. The two flag bits that the unit does not own pass straight through.

Top module: `shcut_unit`

## Requirements
- R1: While reset is asserted and directly after it, `out_valid`, `out_result` and `out_cc` are all zero.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. When `in_valid` is low, `out_result` and `out_cc` keep their previous values.
- R3: Opcode 0 is a logical right shift. The result is `in_a` shifted right by `in_amt[4:0]`, with zeros filled in at the top. `in_amt[5]` has no effect on a shift.
- R4: On a right shift by n, `out_cc[0]` is 1 exactly when any of the n least significant bits of `in_a` is 1, so n = 0 clears it. `out_cc[3:1]` equal `in_cc[3:1]`.
- R5: Opcode 1 is a left shift. The result is `in_a` shifted left by `in_amt[4:0]`, with zeros filled in at the bottom.
- R6: On a left shift by n, `out_cc[1]` is 1 exactly when any of the n most significant bits of `in_a` is 1, so n = 0 clears it. `out_cc[3:2]` and `out_cc[0]` equal the matching bits of `in_cc`.
- R7: Opcode 2 is a scan. A zero `in_a` gives the result 63.
- R8: On a scan of a nonzero `in_a`, the result is the distance of the highest set bit from bit 31. Bit 31 set gives 0, and only bit 0 set gives 31.
- R9: Opcode 3 is a cut with point p = `in_amt` (6 bits). For p below 32, the result is `in_a` shifted left by p, with the top p bits of `in_b` placed in the low p positions.
- R10: On a cut with p of 32 or more, the result is `in_b` shifted left by p − 32.
- R11: On a scan or a cut, `out_cc` equals `in_cc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| in_op | input | 2 | Operation: 0 right shift, 1 left shift, 2 scan, 3 cut |
| in_a | input | 32 | First operand; for a cut, the upper word of the pair |
| in_b | input | 32 | Second operand; for a cut, the lower word of the pair |
| in_amt | input | 6 | Shift amount (low 5 bits) or cut point |
| in_cc | input | 4 | Incoming condition code |
| out_valid | output | 1 | Result registered from the previous cycle's request |
| out_result | output | 32 | Registered result word |
| out_cc | output | 4 | Registered updated condition code |

## Verification
Two kinds of event can occur in the same cycle. The first is a result that changes together with the flag reporting the lost bits. The second is a new request being captured while the previous answer is still on the outputs. The bench provokes the second with back-to-back requests that alternate opcodes and flip the flag bits the unit does not own. Each cycle it compares the whole output against a behavioural reference that walks bit by bit, and it checks that the owned flag and the preserved bits both track the request that produced them. Idle cycles placed between requests show that the outputs hold their values.

// File: rtl/shcut_pkg.sv
package shcut_pkg;
  typedef enum logic [1:0] {
    OP_SHR  = 2'd0,
    OP_SHL  = 2'd1,
    OP_SCAN = 2'd2,
    OP_CUT  = 2'd3
  } shcut_op_e;

  localparam int CC_CARRY = 0;
  localparam int CC_OVFL  = 1;
endpackage

// File: rtl/shcut_shift.sv
module shcut_shift #(
  parameter int W    = 32,
  parameter bit LEFT = 1'b0,
  localparam int SH_W = $clog2(W)
) (
  input  logic [W-1:0]    a,
  input  logic [SH_W-1:0] n,
  output logic [W-1:0]    res,
  output logic            lost
);
  // Mask of the bit positions that leave the word for a shift of n.
  function automatic logic [W-1:0] drop_mask(input logic [SH_W-1:0] k);
    if (LEFT) drop_mask = ~({W{1'b1}} >> k);
    else      drop_mask = ({{(W-1){1'b0}}, 1'b1} << k) - {{(W-1){1'b0}}, 1'b1};
  endfunction

  always_comb begin
    if (LEFT) res = a << n;
    else      res = a >> n;
    lost = |(a & drop_mask(n));
  end
endmodule

// File: rtl/shcut_scan.sv
module shcut_scan #(
  parameter int W = 32,
  localparam int CNT_W = $clog2(W) + 1
) (
  input  logic [W-1:0]     a,
  output logic [CNT_W-1:0] count,
  output logic             is_zero
);
  localparam logic [CNT_W-1:0] ZERO_CODE = CNT_W'(2 * W - 1);

  // Walk upward so that the highest set bit writes last.
  function automatic logic [CNT_W-1:0] lead_zeros(input logic [W-1:0] v);
    logic [CNT_W-1:0] c;
    c = ZERO_CODE;
    for (int i = 0; i < W; i++) begin
      if (v[i]) c = CNT_W'(W - 1 - i);
    end
    return c;
  endfunction

  always_comb begin
    is_zero = (a == '0);
    count   = lead_zeros(a);
  end
endmodule

// File: rtl/shcut_cut.sv
module shcut_cut #(
  parameter int W = 32,
  localparam int P_W = $clog2(W) + 1
) (
  input  logic [W-1:0]   hi,
  input  logic [W-1:0]   lo,
  input  logic [P_W-1:0] p,
  output logic [W-1:0]   res,
  output logic           upper_region
);
  // Window of width W taken from the pair {hi, lo} after a left move by p.
  function automatic logic [W-1:0] window(input logic [W-1:0] h,
                                          input logic [W-1:0] l,
                                          input logic [P_W-1:0] pt);
    int pi;
    pi = int'(pt);
    if (pi < W) window = (h << pi) | (l >> (W - pi));
    else        window = l << (pi - W);
  endfunction

  always_comb begin
    upper_region = (int'(p) < W);
    res          = window(hi, lo, p);
  end
endmodule

// File: rtl/shcut_unit.sv
module shcut_unit
  import shcut_pkg::*;
#(
  parameter int W = 32,
  localparam int SH_W  = $clog2(W),
  localparam int AMT_W = SH_W + 1,
  localparam int CNT_W = SH_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       in_op,
  input  logic [W-1:0]     in_a,
  input  logic [W-1:0]     in_b,
  input  logic [AMT_W-1:0] in_amt,
  input  logic [3:0]       in_cc,
  output logic             out_valid,
  output logic [W-1:0]     out_result,
  output logic [3:0]       out_cc
);
  shcut_op_e op;
  assign op = shcut_op_e'(in_op);

  // Named internal events
  logic [W-1:0]     sh_res [2];
  logic [1:0]       sh_lost;
  logic [CNT_W-1:0] scan_cnt;
  logic             ev_scan_zero;
  logic [W-1:0]     cut_res;
  logic             ev_cut_upper;
  logic [W-1:0]     nxt_result;
  logic [3:0]       nxt_cc;

  // Index 0 shifts right, index 1 shifts left
  for (genvar gi = 0; gi < 2; gi++) begin : g_shift
    shcut_shift #(.W(W), .LEFT(gi == 1)) u_sh (
      .a    (in_a),
      .n    (in_amt[SH_W-1:0]),
      .res  (sh_res[gi]),
      .lost (sh_lost[gi])
    );
  end

  shcut_scan #(.W(W)) u_scan (
    .a       (in_a),
    .count   (scan_cnt),
    .is_zero (ev_scan_zero)
  );

  shcut_cut #(.W(W)) u_cut (
    .hi           (in_a),
    .lo           (in_b),
    .p            (in_amt),
    .res          (cut_res),
    .upper_region (ev_cut_upper)
  );

  always_comb begin
    nxt_result = '0;
    nxt_cc     = in_cc;
    unique case (op)
      OP_SHR: begin
        nxt_result       = sh_res[0];
        nxt_cc[CC_CARRY] = sh_lost[0];
      end
      OP_SHL: begin
        nxt_result      = sh_res[1];
        nxt_cc[CC_OVFL] = sh_lost[1];
      end
      OP_SCAN: nxt_result = W'(scan_cnt);
      OP_CUT:  nxt_result = cut_res;
      default: nxt_result = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_cc     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= nxt_result;
        out_cc     <= nxt_cc;
      end
    end
  end

  // Assertions
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_result) && $stable(out_cc)));

  p_shr_keep_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'd0) |=> out_cc[3:1] == $past(in_cc[3:1]));

  p_shr_zero_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'd0 && in_amt[SH_W-1:0] == '0) |=> !out_cc[0]);

  p_shl_keep_other_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'd1) |=>
      (out_cc[3:2] == $past(in_cc[3:2]) && out_cc[0] == $past(in_cc[0])));

  p_shl_msb_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'd1 && in_amt[SH_W-1:0] != '0 && in_a[W-1]) |=> out_cc[1]);

  p_scan_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'd2 && in_a == '0) |=> out_result == W'(2 * W - 1));

  p_scan_msb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'd2 && in_a[W-1]) |=> out_result == '0);

  p_cut_zero_point_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'd3 && in_amt == '0) |=> out_result == $past(in_a));

  p_cut_half_point_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'd3 && int'(in_amt) == W) |=> out_result == $past(in_b));

  p_cc_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op[1]) |=> out_cc == $past(in_cc));

  p_cut_region_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'd3 && !ev_cut_upper && in_b == '0) |=> out_result == '0);
endmodule

// File: tb/sim_shcut_unit.sv
module sim_shcut_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_op = 2'd0;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic [5:0]  in_amt = '0;
  logic [3:0]  in_cc = '0;
  logic        out_valid;
  logic [31:0] out_result;
  logic [3:0]  out_cc;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic        exp_valid = 1'b0;
  logic [31:0] exp_res = '0;
  logic [3:0]  exp_cc = '0;
  string       tag_res = "R1";
  string       tag_cc  = "R1";

  always #2.5 clk = ~clk;

  shcut_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .in_amt(in_amt), .in_cc(in_cc),
    .out_valid(out_valid), .out_result(out_result), .out_cc(out_cc)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Reference model, bit by bit
  function automatic void model(input logic [1:0] op, input logic [31:0] a,
                                input logic [31:0] b, input logic [5:0] amt,
                                input logic [3:0] cc,
                                output logic [31:0] r, output logic [3:0] f);
    int n;
    int k;
    logic [63:0] pair;
    r = '0;
    f = cc;
    n = int'(amt) % 32;
    case (op)
      2'd0: begin
        for (int j = 0; j + n < 32; j++) r[j] = a[j + n];
        f[0] = 1'b0;
        for (int j = 0; j < n; j++) if (a[j]) f[0] = 1'b1;
        tag_res = "R3"; tag_cc = "R4";
      end
      2'd1: begin
        for (int j = n; j < 32; j++) r[j] = a[j - n];
        f[1] = 1'b0;
        for (int j = 32 - n; j < 32; j++) if (a[j]) f[1] = 1'b1;
        tag_res = "R5"; tag_cc = "R6";
      end
      2'd2: begin
        r = 32'd63;
        for (int j = 31; j >= 0; j--) if (a[j]) begin r = 32'(31 - j); break; end
        tag_res = (a == 0) ? "R7" : "R8"; tag_cc = "R11";
      end
      default: begin
        pair = {a, b};
        for (int j = 0; j < 32; j++) begin
          k = j + 32 - int'(amt);
          if (k >= 0) r[j] = pair[k];
        end
        tag_res = (amt < 6'd32) ? "R9" : "R10"; tag_cc = "R11";
      end
    endcase
  endfunction

  // Called just after a falling edge: drive, wait one cycle, compare.
  task automatic step(input logic v, input logic [1:0] op, input logic [31:0] a,
                      input logic [31:0] b, input logic [5:0] amt, input logic [3:0] cc);
    logic [31:0] r;
    logic [3:0]  f;
    in_valid = v; in_op = op; in_a = a; in_b = b; in_amt = amt; in_cc = cc;
    exp_valid = v;
    if (v) begin
      model(op, a, b, amt, cc, r, f);
      exp_res = r; exp_cc = f;
    end else begin
      tag_res = "R2"; tag_cc = "R2";
    end
    @(negedge clk);
    chk("R2", "out_valid", 32'(out_valid), 32'(exp_valid));
    chk(tag_res, "out_result", out_result, exp_res);
    chk(tag_cc, "out_cc", 32'(out_cc), 32'(exp_cc));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset valid", 32'(out_valid), 32'd0);
    chk("R1", "reset result", out_result, 32'd0);
    chk("R1", "reset cc", 32'(out_cc), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "post reset valid", 32'(out_valid), 32'd0);
    chk("R1", "post reset cc", 32'(out_cc), 32'd0);

    // R3 / R4 right shifts
    step(1, 2'd0, 32'hF000_0001, 0, 6'd1, 4'hE);   // carry set
    step(1, 2'd0, 32'hF000_0010, 0, 6'd4, 4'h1);   // carry cleared
    step(1, 2'd0, 32'hFFFF_FFFF, 0, 6'd0, 4'h1);   // n=0 clears
    step(1, 2'd0, 32'h8000_0000, 0, 6'd31, 4'h5);
    step(1, 2'd0, 32'h0000_0003, 0, 6'd33, 4'h0);  // amt[5] ignored
    // R5 / R6 left shifts
    step(1, 2'd1, 32'h8000_0001, 0, 6'd1, 4'hD);
    step(1, 2'd1, 32'h0F00_0000, 0, 6'd4, 4'h2);
    step(1, 2'd1, 32'hFFFF_FFFF, 0, 6'd0, 4'hF);
    step(1, 2'd1, 32'h0000_0001, 0, 6'd31, 4'h0);
    step(0, 2'd1, 32'hFFFF_FFFF, 0, 6'd5, 4'hA);   // idle hold
    // R7 / R8 scans
    step(1, 2'd2, 32'h0, 0, 6'd9, 4'h9);
    step(1, 2'd2, 32'h8000_0000, 0, 6'd0, 4'h6);
    step(1, 2'd2, 32'h0000_0001, 0, 6'd0, 4'h3);
    step(1, 2'd2, 32'h0001_2345, 0, 6'd0, 4'hC);
    // R9 / R10 cuts
    step(1, 2'd3, 32'h1234_5678, 32'h9ABC_DEF0, 6'd0, 4'h7);
    step(1, 2'd3, 32'h1234_5678, 32'h9ABC_DEF0, 6'd8, 4'h8);
    step(1, 2'd3, 32'h1234_5678, 32'h9ABC_DEF0, 6'd31, 4'h1);
    step(1, 2'd3, 32'h1234_5678, 32'h9ABC_DEF0, 6'd32, 4'h2);
    step(1, 2'd3, 32'h1234_5678, 32'h9ABC_DEF0, 6'd40, 4'h4);
    step(1, 2'd3, 32'h1234_5678, 32'h9ABC_DEF1, 6'd63, 4'hB);
    step(0, 2'd0, 32'h0, 0, 6'd0, 4'h0);
    step(0, 2'd2, 32'h0, 0, 6'd0, 4'hF);

    // Back-to-back mixed traffic with occasional idle cycles
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra;
      ra = $urandom;
      if (i % 5 == 1) ra = ra & (32'hFFFF_FFFF >> ($urandom % 32));
      step(($urandom % 6) != 0, 2'($urandom), ra, $urandom, 6'($urandom), 4'($urandom));
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule